// File: doc/BRIEF.md
# VGA I/O Window SMI Trap

This block sits beside the processor's I/O path and watches every bus cycle. A cycle can fall inside one of three fixed legacy VGA port windows: the monochrome window, the attribute and sequencer window, or the colour window. If it is an I/O cycle and software has armed that window, the block raises a system-management interrupt request. The handler can then emulate the VGA register access in software. Memory cycles are never trapped, even when their address has the same numeric value.

Software controls the block through a small configuration write port. One select value loads the per-window arm bits. The other select value clears status bits, one per window, by writing 1 to each bit to be cleared. The arm bits and the status bits are both visible on output ports. At reset every window is disarmed, so an add-in VGA card answers its ports and no SMI interrupts it.

A three-state controller makes sure that an access produces exactly one request. In ST_IDLE it waits for a qualifying cycle, which is a valid I/O cycle that hits an armed window. On such a cycle it takes the transition IDLE->FIRE and records the cause in the status register. In ST_FIRE the request output is high for one clock. From ST_FIRE the controller goes to ST_HOLD if the bus cycle is still valid (FIRE->HOLD), and back to ST_IDLE if it is not (FIRE->IDLE). ST_HOLD waits for the valid strobe to drop and then takes the transition HOLD->IDLE.

Top module: `vga_io_smi_trap`

## Requirements
- R1: After reset, smi_req is 0, trap_enable is 3'b000 and trap_status is 3'b000. No access raises a request until software arms a window.
- R2: The windows are compared on the full 16-bit I/O address. Window 0 (bit 0) covers 0x3B0 to 0x3BF, window 1 (bit 1) covers 0x3C0 to 0x3CF, and window 2 (bit 2) covers 0x3D0 to 0x3DF. Ports 0x3AF and 0x3E0 match no window.
- R3: An access to a window whose trap_enable bit is 0 raises no request and sets no status bit.
- R4: A cycle with bus_is_io = 0 (a memory cycle) never traps, whatever its address.
- R5: smi_req goes high for exactly one clock, in the cycle after the first clock edge at which a qualifying cycle is seen. If bus_valid stays high for several clocks, only one pulse is produced.
- R6: On a trap, the status bit of the window that was hit is set. It stays set until software clears it, and later traps in other windows add their bits to it (OR).
- R7: A configuration write with cfg_sel = 1 clears each status bit whose cfg_wdata bit is 1 and leaves the other bits unchanged. If a trap sets a bit in the same clock as a write clears it, the bit is set.
- R8: Addresses that differ from a window only in bits [15:12] (for example 0x13B0 or 0xF3D4) do not match.
- R9: A configuration write with cfg_sel = 0 loads cfg_wdata into trap_enable. The new value appears on trap_enable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus cycle is in progress (held for the length of the cycle) |
| bus_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| bus_addr | input | 16 | Cycle address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = load arm bits, 1 = write-1-to-clear status |
| cfg_wdata | input | 3 | Configuration write data, one bit per window |
| smi_req | output | 1 | One-clock SMI request pulse |
| trap_enable | output | 3 | Current per-window arm bits |
| trap_status | output | 3 | Sticky per-window trap cause bits |

## Verification
The assertions check on every cycle that a request pulse never lasts two clocks. They also check that every pulse follows an I/O cycle that hit an armed window, that a pulse always has a status bit set to explain it, and that status bits are never lost unless software clears them. Only the bench's scenarios can show the exact window edges and the address aliases. The same holds for the single pulse on a long-held strobe, the reset-time silence, and the rule that a trap wins over a clear in the same clock.

// File: rtl/vga_trap_pkg.sv
package vga_trap_pkg;
    localparam int unsigned NUM_WIN  = 3;
    localparam int unsigned ADDR_W   = 16;
    localparam int unsigned BASE_TAG = 'h03B;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIRE = 2'd1,
        ST_HOLD = 2'd2
    } trap_state_e;
endpackage

// File: rtl/vga_win_decode.sv
module vga_win_decode #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned NUM_WIN  = 3,
    parameter int unsigned BASE_TAG = 'h03B
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_WIN-1:0] hit
);
    localparam int unsigned TAG_W = ADDR_W - 4;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam logic [TAG_W-1:0] TAG = TAG_W'(BASE_TAG + w);
        localparam logic [ADDR_W-1:0] LO = {TAG, 4'h0};
        localparam logic [ADDR_W-1:0] HI = {TAG, 4'hF};
        // full-width compare: upper alias bits must be zero too
        assign hit[w] = (addr >= LO) && (addr <= HI);
    end
endmodule

// File: rtl/vga_trap_fsm.sv
module vga_trap_fsm
    import vga_trap_pkg::*;
#(
    parameter int unsigned NUM_WIN = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_is_io,
    input  logic [NUM_WIN-1:0] armed_hit,
    output logic               capture,
    output logic               smi_req
);
    trap_state_e state_q, state_d;
    logic        qualify;

    assign qualify = bus_valid && bus_is_io && (|armed_hit);
    assign capture = (state_q == ST_IDLE) && qualify;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (qualify)    state_d = ST_FIRE;
            ST_FIRE: state_d = bus_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: if (!bus_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        smi_req = 1'b0;
        unique case (state_q)
            ST_FIRE: smi_req = 1'b1;
            default: smi_req = 1'b0;
        endcase
    end

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |=> !smi_req); // R5
    AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smi_req) |-> $past(bus_valid && bus_is_io && (|armed_hit))); // R3
    AST_NO_MEM_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_is_io && state_q == ST_IDLE) |=> !smi_req); // R4
endmodule

// File: rtl/vga_trap_regs.sv
module vga_trap_regs #(
    parameter int unsigned NUM_WIN = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [NUM_WIN-1:0] cfg_wdata,
    input  logic               capture,
    input  logic [NUM_WIN-1:0] armed_hit,
    output logic [NUM_WIN-1:0] enable_q,
    output logic [NUM_WIN-1:0] status_q
);
    logic [NUM_WIN-1:0] clr_mask;
    logic [NUM_WIN-1:0] set_mask;

    assign clr_mask = (cfg_we && cfg_sel) ? cfg_wdata : '0;
    assign set_mask = capture ? armed_hit : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (cfg_we && !cfg_sel) begin
            enable_q <= cfg_wdata;
        end
    end

    // set has priority over a simultaneous clear
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_mask) | set_mask;
    end

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(status_q & ~clr_mask)) == $past(status_q & ~clr_mask))); // R6
endmodule

// File: rtl/vga_io_smi_trap.sv
module vga_io_smi_trap
    import vga_trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_is_io,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [NUM_WIN-1:0] cfg_wdata,
    output logic              smi_req,
    output logic [NUM_WIN-1:0] trap_enable,
    output logic [NUM_WIN-1:0] trap_status
);
    logic [NUM_WIN-1:0] win_hit;
    logic [NUM_WIN-1:0] armed_hit;
    logic               capture;

    vga_win_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_WIN (NUM_WIN),
        .BASE_TAG(BASE_TAG)
    ) u_decode (
        .addr(bus_addr),
        .hit (win_hit)
    );

    assign armed_hit = win_hit & trap_enable;

    vga_trap_fsm #(.NUM_WIN(NUM_WIN)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_valid(bus_valid),
        .bus_is_io(bus_is_io),
        .armed_hit(armed_hit),
        .capture  (capture),
        .smi_req  (smi_req)
    );

    vga_trap_regs #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .capture  (capture),
        .armed_hit(armed_hit),
        .enable_q (trap_enable),
        .status_q (trap_status)
    );

    AST_SMI_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> (trap_status != '0)); // R6
endmodule

// File: tb/vga_io_smi_trap_test.sv
module vga_io_smi_trap_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_is_io = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [2:0]  cfg_wdata = '0;
    logic        smi_req;
    logic [2:0]  trap_enable;
    logic [2:0]  trap_status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vga_io_smi_trap uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_is_io(bus_is_io),
        .bus_addr(bus_addr), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .smi_req(smi_req), .trap_enable(trap_enable), .trap_status(trap_status)
    );

    // {is_io, addr[15:0], enable[2:0], exp_smi, exp_status[2:0]}
    localparam int NV = 11;
    localparam logic [23:0] VEC [NV] = '{
        {1'b1, 16'h03B0, 3'b111, 1'b1, 3'b001},  // R2 low edge window 0
        {1'b1, 16'h03BF, 3'b001, 1'b1, 3'b001},  // R2 high edge window 0
        {1'b1, 16'h03C5, 3'b010, 1'b1, 3'b010},  // R2 window 1
        {1'b1, 16'h03DF, 3'b100, 1'b1, 3'b100},  // R2 window 2
        {1'b1, 16'h03AF, 3'b111, 1'b0, 3'b000},  // R2 below
        {1'b1, 16'h03E0, 3'b111, 1'b0, 3'b000},  // R2 above
        {1'b1, 16'h03C0, 3'b101, 1'b0, 3'b000},  // R3 disarmed
        {1'b1, 16'h03D4, 3'b011, 1'b0, 3'b000},  // R3 disarmed
        {1'b0, 16'h03D0, 3'b111, 1'b0, 3'b000},  // R4 memory cycle
        {1'b1, 16'h13B0, 3'b111, 1'b0, 3'b000},  // R8 alias
        {1'b1, 16'hF3D4, 3'b111, 1'b0, 3'b000}   // R8 alias
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [2:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int pulses;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 smi_req", {7'd0, smi_req}, 8'd0);
        check("R1 enable", {5'd0, trap_enable}, 8'd0);
        check("R1 status", {5'd0, trap_status}, 8'd0);

        // R1: access while disarmed after reset
        bus_valid = 1'b1; bus_is_io = 1'b1; bus_addr = 16'h03D4;
        @(negedge clk);
        check("R1 no trap at reset", {4'd0, smi_req, trap_status}, 8'd0);
        bus_valid = 1'b0;

        for (int i = 0; i < NV; i++) begin
            cfg_write(1'b1, 3'b111);
            cfg_write(1'b0, VEC[i][6:4]);
            check("R9 enable readback", {5'd0, trap_enable}, {5'd0, VEC[i][6:4]});
            @(negedge clk);
            bus_valid = 1'b1; bus_is_io = VEC[i][23]; bus_addr = VEC[i][22:7];
            @(negedge clk);
            bus_valid = 1'b0;
            check($sformatf("R2/R3/R4/R8 vec%0d smi", i), {7'd0, smi_req}, {7'd0, VEC[i][3]});
            check($sformatf("R2/R3/R4/R8 vec%0d status", i), {5'd0, trap_status}, {5'd0, VEC[i][2:0]});
            @(negedge clk);
            check($sformatf("R5 vec%0d pulse ends", i), {7'd0, smi_req}, 8'd0);
        end

        // R5: held strobe gives one pulse
        cfg_write(1'b1, 3'b111);
        cfg_write(1'b0, 3'b111);
        pulses = 0;
        @(negedge clk);
        bus_valid = 1'b1; bus_is_io = 1'b1; bus_addr = 16'h03C4;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (smi_req) pulses++;
        end
        bus_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (smi_req) pulses++;
        end
        check("R5 one pulse on held strobe", 8'(pulses), 8'd1);

        // R6: sticky and OR across windows
        repeat (4) @(negedge clk);
        check("R6 status sticky", {5'd0, trap_status}, 8'h02);
        bus_valid = 1'b1; bus_addr = 16'h03BA;
        @(negedge clk);
        bus_valid = 1'b0;
        check("R6 status OR", {5'd0, trap_status}, 8'h03);

        // R7: write-1-to-clear only selected bit
        cfg_write(1'b1, 3'b001);
        check("R7 selective clear", {5'd0, trap_status}, 8'h02);

        // R7: set wins over same-cycle clear
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = 16'h03DA;
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 3'b110;
        @(negedge clk);
        bus_valid = 1'b0; cfg_we = 1'b0;
        check("R7 set beats clear", {5'd0, trap_status}, 8'h04);
        check("R5 pulse with clear", {7'd0, smi_req}, 8'd1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule